// File: doc/BRIEF.md
# Snooping MOESI Coherence Controller

This block keeps two to four private write-back caches coherent over one shared snoop bus and a backing memory. Each core drives one load or store request at a time. A round-robin arbiter picks one core, and a central sequencer carries out the whole coherence transaction for that core before it takes the next one. So all modifications to a line are seen in one global order. Every cache line is in one of five states: Modified, Owned, Exclusive, Shared or Invalid. A dirty line can pass from cache to cache without first being written back to memory.

The bus is visible at the ports, so integration logic and tests can watch coherence traffic. The bus signals show each transaction: a read, a read-for-ownership or an upgrade. They show the requesting core and whether the data came from another cache. The memory write-back signals show each eviction of a dirty line. Memory is a simple fixed-latency model. A fill from another cache takes a separate, shorter fixed delay.

Top module: `moesi_coherence_ctrl`

## Requirements
- R1: After reset, no response, bus or memory-write output is active. Every line is Invalid, so the first access to any address misses and puts a transaction on the bus.
- R2: A read miss with no other cached copy fills the line Exclusive. A read miss that hits a copy in another cache fills Shared, and an Exclusive holder drops to Shared, so its next store needs an upgrade.
- R3: A store that hits a Modified or Exclusive line completes with no bus transaction and no memory write. An Exclusive line becomes Modified.
- R4: A store that hits a Shared or Owned line issues one upgrade transaction (bus_op = 2). The upgrade invalidates every other copy and leaves the requester Modified, so other cores miss on their next access.
- R5: A read miss on a line that another cache holds Modified takes its data from that cache (bus_c2c = 1), with no memory write. The holder moves to Owned.
- R6: An Owned holder supplies the data to later readers. Only an Owned or Modified holder writes the line back when it evicts it. Evicting a Shared or Exclusive line writes nothing, even when the Shared data is newer than memory.
- R7: Each cache is direct-mapped, and the set index is the low log2(NUM_SETS) address bits. A miss whose victim is Modified or Owned first does exactly one memory write of the victim's address and data, and the fetch goes on the bus in the next cycle. A clean victim causes no write. A read miss uses bus_op = 0. A store miss uses bus_op = 1, invalidates other copies and ends Modified.
- R8: Only one transaction is in flight, and at most one response is active per cycle. After core g is granted, arbitration priority starts at core g+1 and wraps around.
- R9: Every load returns the value of the most recent store to that address in the global transaction order.
- R10: At any time, a line held Modified or Exclusive has no other valid copy, and at most one cache holds a given line Owned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CORES | Per-core request, held until that core's response |
| req_write | input | NUM_CORES | Per-core store (1) or load (0) |
| req_addr | input | NUM_CORES*ADDR_W | Per-core word address, core c at bits [c*ADDR_W +: ADDR_W] |
| req_wdata | input | NUM_CORES*DATA_W | Per-core store data |
| resp_valid | output | NUM_CORES | One-cycle completion pulse for the served core |
| resp_rdata | output | DATA_W | Load data, valid with resp_valid |
| bus_valid | output | 1 | A coherence transaction is on the bus this cycle |
| bus_op | output | 2 | 0 read, 1 read-for-ownership, 2 upgrade |
| bus_core | output | CORE_W | Requesting core |
| bus_addr | output | ADDR_W | Line address on the bus |
| bus_c2c | output | 1 | Fill data comes from another cache |
| mem_we | output | 1 | Victim write-back to memory this cycle |
| mem_waddr | output | ADDR_W | Write-back address |
| mem_wdata | output | DATA_W | Write-back data |

## Verification
The bench builds the block with its defaults: three cores, two sets per cache and a three-bit address, so there are four tags that compete for each set. With so few sets, evictions of Owned, Shared and Exclusive victims happen within a few requests. With three cores, one line can be Owned in one cache and Shared in two others, and the wrap-around of the round-robin arbiter can be observed. Directed sequences walk a line through every state change. A sweep over every core, address and operation then checks each load against a flat memory model kept in the bench.

// File: rtl/moesi_pkg.sv
package moesi_pkg;
   typedef enum logic [2:0] {
      LS_I = 3'd0,
      LS_S = 3'd1,
      LS_E = 3'd2,
      LS_O = 3'd3,
      LS_M = 3'd4
   } line_st_e;

   typedef enum logic [1:0] {
      OP_RD  = 2'd0,
      OP_RDX = 2'd1,
      OP_UPG = 2'd2
   } bus_op_e;

   function automatic logic st_dirty(line_st_e s);
      return (s == LS_M) || (s == LS_O);
   endfunction
endpackage

// File: rtl/moesi_line_store.sv
module moesi_line_store
   import moesi_pkg::*;
#(
   parameter int NUM_SETS = 2,
   parameter int TAG_W    = 2,
   parameter int DATA_W   = 8,
   localparam int IDX_W   = $clog2(NUM_SETS)
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [IDX_W-1:0]          idx,
   output line_st_e                  rd_st,
   output logic [TAG_W-1:0]          rd_tag,
   output logic [DATA_W-1:0]         rd_data,
   input  logic                      wr_en,
   input  line_st_e                  wr_st,
   input  logic [TAG_W-1:0]          wr_tag,
   input  logic [DATA_W-1:0]         wr_data,
   output logic [NUM_SETS*3-1:0]     st_all,
   output logic [NUM_SETS*TAG_W-1:0] tag_all
);
   line_st_e          st_q  [NUM_SETS];
   logic [TAG_W-1:0]  tag_q [NUM_SETS];
   logic [DATA_W-1:0] dat_q [NUM_SETS];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int s = 0; s < NUM_SETS; s++) begin
            st_q[s]  <= LS_I;
            tag_q[s] <= '0;
            dat_q[s] <= '0;
         end
      end else if (wr_en) begin
         st_q[idx]  <= wr_st;
         tag_q[idx] <= wr_tag;
         dat_q[idx] <= wr_data;
      end
   end

   assign rd_st   = st_q[idx];
   assign rd_tag  = tag_q[idx];
   assign rd_data = dat_q[idx];

   for (genvar s = 0; s < NUM_SETS; s++) begin : g_flat
      assign st_all[s*3 +: 3]          = st_q[s];
      assign tag_all[s*TAG_W +: TAG_W] = tag_q[s];
   end
endmodule

// File: rtl/moesi_rr_arbiter.sv
module moesi_rr_arbiter #(
   parameter int N       = 3,
   localparam int IDX_W  = (N > 1) ? $clog2(N) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N-1:0]     req,
   input  logic             adv,
   output logic             gnt_any,
   output logic [IDX_W-1:0] gnt_idx
);
   logic [IDX_W-1:0] ptr_q;

   always_comb begin
      int j;
      gnt_any = 1'b0;
      gnt_idx = '0;
      for (int k = N - 1; k >= 0; k--) begin
         j = (int'(ptr_q) + k) % N;
         if (req[j]) begin
            gnt_any = 1'b1;
            gnt_idx = IDX_W'(j);
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr_q <= '0;
      else if (adv && gnt_any)
         ptr_q <= (gnt_idx == IDX_W'(N - 1)) ? '0 : gnt_idx + 1'b1;
   end
endmodule

// File: rtl/moesi_backing_mem.sv
module moesi_backing_mem #(
   parameter int ADDR_W  = 3,
   parameter int DATA_W  = 8,
   parameter int LAT     = 2,
   localparam int DEPTH  = 1 << ADDR_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic              re,
   input  logic [ADDR_W-1:0] raddr,
   output logic              rvalid,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] mem_q [DEPTH];
   logic [LAT-1:0]    vld_q;
   logic [DATA_W-1:0] pipe_q [LAT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int a = 0; a < DEPTH; a++) mem_q[a] <= '0;
         for (int p = 0; p < LAT; p++) pipe_q[p] <= '0;
         vld_q <= '0;
      end else begin
         if (we) mem_q[waddr] <= wdata;
         vld_q[0]  <= re;
         pipe_q[0] <= mem_q[raddr];
         for (int p = 1; p < LAT; p++) begin
            vld_q[p]  <= vld_q[p-1];
            pipe_q[p] <= pipe_q[p-1];
         end
      end
   end

   assign rvalid = vld_q[LAT-1];
   assign rdata  = pipe_q[LAT-1];
endmodule

// File: rtl/moesi_coherence_ctrl.sv
module moesi_coherence_ctrl
   import moesi_pkg::*;
#(
   parameter int NUM_CORES = 3,
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 8,
   parameter int NUM_SETS  = 2,
   parameter int MEM_LAT   = 2,
   parameter int SNOOP_LAT = 1,
   localparam int CORE_W   = (NUM_CORES > 1) ? $clog2(NUM_CORES) : 1,
   localparam int IDX_W    = $clog2(NUM_SETS),
   localparam int TAG_W    = ADDR_W - IDX_W,
   localparam int CNT_W    = $clog2(SNOOP_LAT + 1)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic [NUM_CORES-1:0]          req_valid,
   input  logic [NUM_CORES-1:0]          req_write,
   input  logic [NUM_CORES*ADDR_W-1:0]   req_addr,
   input  logic [NUM_CORES*DATA_W-1:0]   req_wdata,
   output logic [NUM_CORES-1:0]          resp_valid,
   output logic [DATA_W-1:0]             resp_rdata,
   output logic                          bus_valid,
   output logic [1:0]                    bus_op,
   output logic [CORE_W-1:0]             bus_core,
   output logic [ADDR_W-1:0]             bus_addr,
   output logic                          bus_c2c,
   output logic                          mem_we,
   output logic [ADDR_W-1:0]             mem_waddr,
   output logic [DATA_W-1:0]             mem_wdata
);
   if (NUM_CORES < 2 || NUM_CORES > 4) begin : g_bad_cores
      $error("NUM_CORES must lie in 2..4");
   end
   if (NUM_SETS < 2 || (NUM_SETS & (NUM_SETS - 1)) != 0) begin : g_bad_sets
      $error("NUM_SETS must be a power of two, at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end
   if (MEM_LAT < 1 || SNOOP_LAT < 1) begin : g_bad_lat
      $error("latencies must be at least one cycle");
   end

   typedef enum logic [2:0] {C_IDLE, C_LOOK, C_WB, C_BUS, C_WAIT, C_RESP} ctrl_e;

   ctrl_e              cs;
   logic [CORE_W-1:0]  rq_core;
   logic               rq_wr;
   logic [ADDR_W-1:0]  rq_addr;
   logic [DATA_W-1:0]  rq_wdata;
   bus_op_e            rq_op;
   logic               c2c_q;
   logic [DATA_W-1:0]  c2c_dat_q;
   logic [CNT_W-1:0]   cnt_q;
   logic [DATA_W-1:0]  rdata_q;

   logic [IDX_W-1:0]   rq_idx;
   logic [TAG_W-1:0]   rq_tag;
   assign rq_idx = rq_addr[IDX_W-1:0];
   assign rq_tag = rq_addr[ADDR_W-1:IDX_W];

   line_st_e           c_st   [NUM_CORES];
   logic [TAG_W-1:0]   c_tag  [NUM_CORES];
   logic [DATA_W-1:0]  c_dat  [NUM_CORES];
   logic               c_wen  [NUM_CORES];
   line_st_e           c_wst  [NUM_CORES];
   logic [TAG_W-1:0]   c_wtag [NUM_CORES];
   logic [DATA_W-1:0]  c_wdat [NUM_CORES];

   logic [NUM_CORES*NUM_SETS*3-1:0]     st_flat;
   logic [NUM_CORES*NUM_SETS*TAG_W-1:0] tag_flat;

   for (genvar g = 0; g < NUM_CORES; g++) begin : g_cache
      moesi_line_store #(
         .NUM_SETS(NUM_SETS), .TAG_W(TAG_W), .DATA_W(DATA_W)
      ) u_store (
         .clk     (clk),
         .rst_n   (rst_n),
         .idx     (rq_idx),
         .rd_st   (c_st[g]),
         .rd_tag  (c_tag[g]),
         .rd_data (c_dat[g]),
         .wr_en   (c_wen[g]),
         .wr_st   (c_wst[g]),
         .wr_tag  (c_wtag[g]),
         .wr_data (c_wdat[g]),
         .st_all  (st_flat[g*NUM_SETS*3 +: NUM_SETS*3]),
         .tag_all (tag_flat[g*NUM_SETS*TAG_W +: NUM_SETS*TAG_W])
      );
   end

   // arbitration
   logic              gnt_any;
   logic [CORE_W-1:0] gnt_idx;

   moesi_rr_arbiter #(.N(NUM_CORES)) u_arb (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req_valid),
      .adv     (cs == C_IDLE),
      .gnt_any (gnt_any),
      .gnt_idx (gnt_idx)
   );

   // backing memory
   logic              mem_re;
   logic              mem_rvalid;
   logic [DATA_W-1:0] mem_rdata;

   moesi_backing_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .LAT(MEM_LAT)) u_mem (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (mem_we),
      .waddr  (mem_waddr),
      .wdata  (mem_wdata),
      .re     (mem_re),
      .raddr  (rq_addr),
      .rvalid (mem_rvalid),
      .rdata  (mem_rdata)
   );

   // lookup of requester line and snoop of the others
   line_st_e          loc_st;
   logic [TAG_W-1:0]  loc_tag;
   logic [DATA_W-1:0] loc_dat;
   logic              loc_hit;
   logic              oth_hit [NUM_CORES];
   logic              oth_any;
   logic              own_any;
   logic [DATA_W-1:0] own_dat;

   always_comb begin
      loc_st  = LS_I;
      loc_tag = '0;
      loc_dat = '0;
      oth_any = 1'b0;
      own_any = 1'b0;
      own_dat = '0;
      for (int c = 0; c < NUM_CORES; c++) begin
         oth_hit[c] = 1'b0;
         if (CORE_W'(c) == rq_core) begin
            loc_st  = c_st[c];
            loc_tag = c_tag[c];
            loc_dat = c_dat[c];
         end else if (c_st[c] != LS_I && c_tag[c] == rq_tag) begin
            oth_hit[c] = 1'b1;
            oth_any    = 1'b1;
            if (st_dirty(c_st[c])) begin
               own_any = 1'b1;
               own_dat = c_dat[c];
            end
         end
      end
   end
   assign loc_hit = (loc_st != LS_I) && (loc_tag == rq_tag);

   logic              wait_done;
   logic [DATA_W-1:0] fill_dat;
   assign fill_dat  = c2c_q ? c2c_dat_q : mem_rdata;
   assign wait_done = (cs == C_WAIT) && (c2c_q ? (cnt_q == '0) : mem_rvalid);

   // per-cache line updates
   always_comb begin
      for (int c = 0; c < NUM_CORES; c++) begin
         logic mine;
         mine      = (CORE_W'(c) == rq_core);
         c_wen[c]  = 1'b0;
         c_wst[c]  = c_st[c];
         c_wtag[c] = c_tag[c];
         c_wdat[c] = c_dat[c];
         unique case (cs)
            C_LOOK: begin
               if (mine && loc_hit && rq_wr && (loc_st == LS_M || loc_st == LS_E)) begin
                  c_wen[c]  = 1'b1;
                  c_wst[c]  = LS_M;
                  c_wdat[c] = rq_wdata;
               end
            end
            C_BUS: begin
               if (rq_op == OP_UPG) begin
                  if (mine) begin
                     c_wen[c]  = 1'b1;
                     c_wst[c]  = LS_M;
                     c_wdat[c] = rq_wdata;
                  end else if (oth_hit[c]) begin
                     c_wen[c] = 1'b1;
                     c_wst[c] = LS_I;
                  end
               end
            end
            C_WAIT: begin
               if (wait_done) begin
                  if (mine) begin
                     c_wen[c]  = 1'b1;
                     c_wtag[c] = rq_tag;
                     c_wst[c]  = rq_wr ? LS_M : (oth_any ? LS_S : LS_E);
                     c_wdat[c] = rq_wr ? rq_wdata : fill_dat;
                  end else if (oth_hit[c]) begin
                     c_wen[c] = 1'b1;
                     if (rq_wr)                  c_wst[c] = LS_I;
                     else if (c_st[c] == LS_M)   c_wst[c] = LS_O;
                     else if (c_st[c] == LS_E)   c_wst[c] = LS_S;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   // sequencer
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cs        <= C_IDLE;
         rq_core   <= '0;
         rq_wr     <= 1'b0;
         rq_addr   <= '0;
         rq_wdata  <= '0;
         rq_op     <= OP_RD;
         c2c_q     <= 1'b0;
         c2c_dat_q <= '0;
         cnt_q     <= '0;
         rdata_q   <= '0;
      end else begin
         unique case (cs)
            C_IDLE: begin
               if (gnt_any) begin
                  rq_core  <= gnt_idx;
                  rq_wr    <= req_write[gnt_idx];
                  rq_addr  <= req_addr[gnt_idx*ADDR_W +: ADDR_W];
                  rq_wdata <= req_wdata[gnt_idx*DATA_W +: DATA_W];
                  cs       <= C_LOOK;
               end
            end
            C_LOOK: begin
               if (loc_hit) begin
                  if (!rq_wr) begin
                     rdata_q <= loc_dat;
                     cs      <= C_RESP;
                  end else if (loc_st == LS_M || loc_st == LS_E) begin
                     cs <= C_RESP;
                  end else begin
                     rq_op <= OP_UPG;
                     cs    <= C_BUS;
                  end
               end else begin
                  rq_op <= rq_wr ? OP_RDX : OP_RD;
                  cs    <= st_dirty(loc_st) ? C_WB : C_BUS;
               end
            end
            C_WB: cs <= C_BUS;
            C_BUS: begin
               if (rq_op == OP_UPG) begin
                  cs <= C_RESP;
               end else begin
                  c2c_q     <= own_any;
                  c2c_dat_q <= own_dat;
                  cnt_q     <= CNT_W'(SNOOP_LAT - 1);
                  cs        <= C_WAIT;
               end
            end
            C_WAIT: begin
               if (wait_done) begin
                  rdata_q <= fill_dat;
                  cs      <= C_RESP;
               end else if (c2c_q && cnt_q != '0) begin
                  cnt_q <= cnt_q - 1'b1;
               end
            end
            C_RESP: cs <= C_IDLE;
            default: cs <= C_IDLE;
         endcase
      end
   end

   assign mem_re = (cs == C_BUS) && (rq_op != OP_UPG) && !own_any;

   for (genvar g = 0; g < NUM_CORES; g++) begin : g_resp
      assign resp_valid[g] = (cs == C_RESP) && (rq_core == CORE_W'(g));
   end
   assign resp_rdata = rdata_q;
   assign bus_valid  = (cs == C_BUS);
   assign bus_op     = rq_op;
   assign bus_core   = rq_core;
   assign bus_addr   = rq_addr;
   assign bus_c2c    = bus_valid && (rq_op != OP_UPG) && own_any;
   assign mem_we     = (cs == C_WB);
   assign mem_waddr  = {loc_tag, rq_idx};
   assign mem_wdata  = loc_dat;
endmodule

// File: rtl/moesi_coherence_chk.sv
module moesi_coherence_chk
   import moesi_pkg::*;
#(
   parameter int NUM_CORES = 3,
   parameter int NUM_SETS  = 2,
   parameter int TAG_W     = 2
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic [NUM_CORES-1:0]                resp_valid,
   input logic                                bus_valid,
   input logic [1:0]                          bus_op,
   input logic                                mem_we,
   input logic [NUM_CORES*NUM_SETS*3-1:0]     st_flat,
   input logic [NUM_CORES*NUM_SETS*TAG_W-1:0] tag_flat
);
   logic viol;

   always_comb begin
      viol = 1'b0;
      for (int s = 0; s < NUM_SETS; s++) begin
         for (int i = 0; i < NUM_CORES; i++) begin
            for (int j = 0; j < NUM_CORES; j++) begin
               logic [2:0]       si, sj;
               logic [TAG_W-1:0] ti, tj;
               si = st_flat[(i*NUM_SETS+s)*3 +: 3];
               sj = st_flat[(j*NUM_SETS+s)*3 +: 3];
               ti = tag_flat[(i*NUM_SETS+s)*TAG_W +: TAG_W];
               tj = tag_flat[(j*NUM_SETS+s)*TAG_W +: TAG_W];
               if (i != j && si != 3'(LS_I) && sj != 3'(LS_I) && ti == tj) begin
                  if (si == 3'(LS_M) || si == 3'(LS_E) ||
                      (si == 3'(LS_O) && sj == 3'(LS_O)))
                     viol = 1'b1;
               end
            end
         end
      end
   end

   assert_single_owner_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !viol);

   assert_one_response_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(resp_valid));

   assert_bus_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |=> !bus_valid);

   assert_wb_then_fetch_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_we |=> (bus_valid && bus_op != 2'd2));

   assert_upgrade_completes_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && bus_op == 2'd2) |=> (resp_valid != '0));
endmodule

bind moesi_coherence_ctrl moesi_coherence_chk #(
   .NUM_CORES (NUM_CORES),
   .NUM_SETS  (NUM_SETS),
   .TAG_W     (TAG_W)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .resp_valid (resp_valid),
   .bus_valid  (bus_valid),
   .bus_op     (bus_op),
   .mem_we     (mem_we),
   .st_flat    (st_flat),
   .tag_flat   (tag_flat)
);

// File: tb/tb_moesi_coherence_ctrl.sv
module tb_moesi_coherence_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int NC = 3;
   localparam int AW = 3;
   localparam int DW = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [NC-1:0]    req_valid = '0;
   logic [NC-1:0]    req_write = '0;
   logic [NC*AW-1:0] req_addr = '0;
   logic [NC*DW-1:0] req_wdata = '0;
   logic [NC-1:0]    resp_valid;
   logic [DW-1:0]    resp_rdata;
   logic             bus_valid;
   logic [1:0]       bus_op;
   logic [1:0]       bus_core;
   logic [AW-1:0]    bus_addr;
   logic             bus_c2c;
   logic             mem_we;
   logic [AW-1:0]    mem_waddr;
   logic [DW-1:0]    mem_wdata;

   always #(CLK_PERIOD/2) clk = ~clk;

   moesi_coherence_ctrl dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .resp_valid(resp_valid), .resp_rdata(resp_rdata),
      .bus_valid(bus_valid), .bus_op(bus_op), .bus_core(bus_core),
      .bus_addr(bus_addr), .bus_c2c(bus_c2c),
      .mem_we(mem_we), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   int bus_cnt = 0, wb_cnt = 0, bus_cyc = 0, wb_cyc = 0;
   logic [1:0]    last_op;
   logic          last_c2c;
   logic [AW-1:0] last_wa;
   logic [DW-1:0] last_wd;
   logic [DW-1:0] gold [1 << AW];

   always @(posedge clk) cyc <= cyc + 1;

   always @(negedge clk) begin
      if (rst_n) begin
         if (bus_valid) begin
            bus_cnt++;
            last_op  = bus_op;
            last_c2c = bus_c2c;
            bus_cyc  = cyc;
         end
         if (mem_we) begin
            wb_cnt++;
            last_wa = mem_waddr;
            last_wd = mem_wdata;
            wb_cyc  = cyc;
         end
      end
   end

   task automatic chk(input bit ok, input string rq, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", rq, act, exp);
      end
   endtask

   int nb, nw;
   logic [DW-1:0] rd;

   task automatic do_req(input int c, input bit wr, input int a, input logic [DW-1:0] d);
      @(negedge clk);
      nb = bus_cnt;
      nw = wb_cnt;
      req_write[c] = wr;
      req_addr[c*AW +: AW] = AW'(a);
      req_wdata[c*DW +: DW] = d;
      req_valid[c] = 1'b1;
      do @(negedge clk); while (!resp_valid[c]);
      rd = resp_rdata;
      req_valid[c] = 1'b0;
      if (wr) gold[a] = d;
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL R9: watchdog expired, actual hang expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end

   initial begin
      for (int a = 0; a < (1 << AW); a++) gold[a] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(resp_valid == '0 && !bus_valid && !mem_we, "R1", int'(resp_valid), 0);

      // R1 first access misses; R2 fills Exclusive from memory
      do_req(0, 0, 2, 0);
      chk(bus_cnt - nb == 1, "R1", bus_cnt - nb, 1);
      chk(last_op == 2'd0 && !last_c2c && rd == 0, "R2", int'(rd), 0);
      // R3 store on Exclusive then on Modified: silent
      do_req(0, 1, 2, 8'h11);
      chk(bus_cnt == nb && wb_cnt == nw, "R3", bus_cnt - nb, 0);
      do_req(0, 1, 2, 8'h12);
      chk(bus_cnt == nb && wb_cnt == nw, "R3", bus_cnt - nb, 0);
      // R5 read of a Modified line: cache to cache, no write-back
      do_req(1, 0, 2, 0);
      chk(last_c2c && wb_cnt == nw, "R5", int'(last_c2c), 1);
      chk(rd == 8'h12, "R5", int'(rd), 'h12);
      // R4 store on Owned: upgrade
      do_req(0, 1, 2, 8'h13);
      chk(bus_cnt - nb == 1 && last_op == 2'd2 && wb_cnt == nw, "R4", int'(last_op), 2);
      // R4 invalidated core misses; R5 supply again
      do_req(1, 0, 2, 0);
      chk(bus_cnt - nb == 1 && last_c2c && rd == 8'h13, "R4", int'(rd), 'h13);
      // R6 Owned holder supplies a second reader
      do_req(2, 0, 2, 0);
      chk(last_c2c && rd == 8'h13 && wb_cnt == nw, "R6", int'(rd), 'h13);
      // R6 evicting dirty-Shared line writes nothing
      do_req(1, 0, 4, 0);
      chk(wb_cnt == nw && !last_c2c && rd == 0, "R6", wb_cnt - nw, 0);
      // R6/R7 evicting the Owned line writes it back before the fetch
      do_req(0, 0, 4, 0);
      chk(wb_cnt - nw == 1 && last_wa == 3'd2 && last_wd == 8'h13, "R6", int'(last_wd), 'h13);
      chk(bus_cyc == wb_cyc + 1, "R7", bus_cyc - wb_cyc, 1);
      chk(!last_c2c && rd == 0, "R2", int'(rd), 0);
      // R2 former Exclusive holder now Shared: its store upgrades
      do_req(1, 1, 4, 8'h21);
      chk(last_op == 2'd2 && bus_cnt - nb == 1, "R2", int'(last_op), 2);
      do_req(0, 0, 4, 0);
      chk(last_c2c && rd == 8'h21, "R5", int'(rd), 'h21);
      // R2 Exclusive fill then demotion on another read
      do_req(2, 0, 1, 0);
      do_req(0, 0, 1, 0);
      chk(!last_c2c && rd == 0, "R2", int'(rd), 0);
      do_req(2, 1, 1, 8'h31);
      chk(last_op == 2'd2 && bus_cnt - nb == 1 && wb_cnt == nw, "R2", int'(last_op), 2);
      // R7 store miss with Owned victim
      do_req(1, 1, 0, 8'h41);
      chk(wb_cnt - nw == 1 && last_wa == 3'd4 && last_wd == 8'h21, "R7", int'(last_wd), 'h21);
      chk(last_op == 2'd1 && bus_cyc == wb_cyc + 1, "R7", int'(last_op), 1);
      // R7 store miss with clean victim
      do_req(2, 1, 6, 8'h61);
      chk(wb_cnt == nw && last_op == 2'd1 && !last_c2c, "R7", wb_cnt - nw, 0);
      // R9 written-back value comes from memory
      do_req(0, 0, 2, 0);
      chk(rd == 8'h13 && !last_c2c && wb_cnt == nw, "R9", int'(rd), 'h13);

      // R8 round-robin: last grant was core 0, so order 1, 2, 0
      begin
         int order [3];
         int got = 0;
         @(negedge clk);
         for (int c = 0; c < NC; c++) begin
            req_write[c] = 1'b0;
            req_addr[c*AW +: AW] = AW'(2 * c + 1);
            req_valid[c] = 1'b1;
         end
         while (got < 3) begin
            @(negedge clk);
            for (int c = 0; c < NC; c++) begin
               if (resp_valid[c]) begin
                  order[got] = c;
                  got++;
                  chk(resp_rdata == gold[2 * c + 1], "R9", int'(resp_rdata), int'(gold[2 * c + 1]));
                  req_valid[c] = 1'b0;
               end
            end
         end
         chk(order[0] == 1 && order[1] == 2 && order[2] == 0, "R8",
             order[0] * 100 + order[1] * 10 + order[2], 120);
      end

      // R9 sweep over every core, address and operation
      for (int p = 0; p < 3; p++) begin
         for (int a = 0; a < (1 << AW); a++) begin
            for (int c = 0; c < NC; c++) begin
               for (int w = 0; w < 2; w++) begin
                  int cc;
                  cc = (c + p + a) % NC;
                  if (w == 1) begin
                     do_req(cc, 1, a, DW'(p * 37 + a * 5 + cc * 11 + 1));
                  end else begin
                     do_req(cc, 0, (a + p * 3) % 8, 0);
                     chk(rd == gold[(a + p * 3) % 8], "R9", int'(rd), int'(gold[(a + p * 3) % 8]));
                  end
               end
            end
         end
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule